// File: doc/BRIEF.md
# Calendar Time-of-Year Counter with Match Alarms

This block keeps a running calendar (sixteenths of a second, seconds, minutes, hours, day of month, month and year) that moves forward on a slow tick-enable input pulsing at 16 Hz. Software reaches it through a simple 32-bit word port with one write strobe and one read strobe. Through this port it sets and reads the time, programs three alarm words and writes a control word. The whole unit runs only while two control bits are both set. While the unit is stopped, the calendar holds its value, reads of the time return zero, and writes to the time, the year and the alarms are dropped.

Each alarm compares its stored second, minute, hour, day, month and low six year bits against the running calendar. A match sets a sticky pending flag for that alarm. The interrupt output is the OR of the three flags. A flag clears when its alarm register is rewritten, or on reset.

The run state is a two-state machine. In `UNIT_OFF` the unit is stopped. The transition `GO_ON` to `UNIT_ON` is taken on a control write with bits 11 and 8 both 1. In `UNIT_ON` the unit runs. The transition `GO_OFF` back to `UNIT_OFF` is taken on a control write where either bit is 0. Any other cycle holds the current state.

Top module: `toy_calendar`

## Requirements
- R1: Reset clears the control word and the three alarm words, drops the interrupt, and sets the calendar to month 1, day 1, 00:00:00.0, year 0.
- R2: The control word at offset 0x40 reads back as written. The unit runs only while control bit 11 and control bit 8 are both 1.
- R3: While the unit is stopped, the calendar does not advance. Reads of offsets 0x2C and 0x30 return zero. Writes to offsets 0x24, 0x28, 0x34, 0x38 and 0x3C are ignored.
- R4: The time word is written at 0x24 and read at 0x2C. It packs month (1 to 12) in bits 31:26, day in 25:21, hour in 20:16, minute in 15:10, second in 9:4 and sixteenths in 3:0. The year is written at 0x28 and read at 0x30 as a plain binary number. Read data appears one cycle after the read strobe and then holds.
- R5: Each cycle with the tick input high and the unit running adds one sixteenth. The sixteenths count wraps from 15 to 0 and carries into the seconds.
- R6: Seconds wrap at 60 and minutes wrap at 60, each carrying upward. Hours wrap at 24 into the day. Month 12 wraps to month 1 and increments the year.
- R7: Day 30 is the last day of months 4, 6, 9 and 11. February ends on day 29 when the year is divisible by 4, otherwise on day 28. All other months end on day 31. The day after the last day is day 1 of the next month.
- R8: The alarm words sit at 0x34, 0x38 and 0x3C, for alarms 0, 1 and 2. Each packs the low six year bits in 31:26, month in 25:22, day in 21:17, hour in 16:12, minute in 11:6 and second in 5:0. Each reads back its stored value whether or not the unit runs.
- R9: When the running calendar equals an alarm in all six fields, that alarm's pending flag is set one cycle later, and the interrupt is the OR of all pending flags. A stopped unit sets no flag.
- R10: A pending flag holds after the calendar moves past the match. It clears in the cycle its alarm word is written while the unit runs.
- R11: Offsets that are not listed read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle enable at 16 Hz; advances the calendar by one sixteenth of a second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq | output | 1 | Level interrupt; OR of the alarm pending flags |

## Verification
A write takes effect at the clock edge that samples its strobe. Read data is registered, so it is due one cycle after the read strobe. A tick updates the calendar at the edge that samples it. A pending flag, and so the interrupt, follows the calendar match by one further edge.

The bench drives each strobe for exactly one cycle between falling edges and compares read data at the next falling edge. Before it compares the interrupt, it waits one more falling edge after a tick or an alarm write. This way every comparison falls in the first cycle where the new value is due.

// File: rtl/toy_pkg.sv
package toy_pkg;

    typedef enum logic {
        UNIT_OFF = 1'b0,
        UNIT_ON  = 1'b1
    } unit_state_e;

    typedef struct packed {
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [3:0] sub;
    } cal_t;

    localparam logic [7:0] OFS_TIME_WR  = 8'h24;
    localparam logic [7:0] OFS_YEAR_WR  = 8'h28;
    localparam logic [7:0] OFS_TIME_RD  = 8'h2C;
    localparam logic [7:0] OFS_YEAR_RD  = 8'h30;
    localparam logic [7:0] OFS_ALARM0   = 8'h34;
    localparam logic [7:0] OFS_CTRL     = 8'h40;
    localparam int         CTRL_CAL_BIT = 11;
    localparam int         CTRL_OSC_BIT = 8;

    localparam cal_t CAL_RESET = '{mon: 4'd1, day: 5'd1, hour: 5'd0,
                                   min: 6'd0, sec: 6'd0, sub: 4'd0};

    function automatic logic [4:0] days_in_month(input logic [3:0] mon,
                                                 input logic leap);
        case (mon)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic logic [31:0] pack_time(input cal_t c);
        return {2'b00, c.mon, c.day, c.hour, c.min, c.sec, c.sub};
    endfunction

    function automatic cal_t unpack_time(input logic [29:0] w);
        cal_t c;
        c.mon  = w[29:26];
        c.day  = w[25:21];
        c.hour = w[20:16];
        c.min  = w[15:10];
        c.sec  = w[9:4];
        c.sub  = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/toy_cal_core.sv
module toy_cal_core
    import toy_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              ld_fields,
    input  logic              ld_year,
    input  logic [29:0]       field_word,
    input  logic [YEAR_W-1:0] year_word,
    output cal_t              cal_q,
    output logic [YEAR_W-1:0] year_q
);

    cal_t       cal_nxt;
    logic       year_carry;
    logic [4:0] last_day;

    always_comb begin
        cal_nxt    = cal_q;
        year_carry = 1'b0;
        last_day   = days_in_month(cal_q.mon, year_q[1:0] == 2'b00);
        if (cal_q.sub != 4'd15) begin
            cal_nxt.sub = cal_q.sub + 4'd1;
        end else begin
            cal_nxt.sub = 4'd0;
            if (cal_q.sec < 6'd59) begin
                cal_nxt.sec = cal_q.sec + 6'd1;
            end else begin
                cal_nxt.sec = 6'd0;
                if (cal_q.min < 6'd59) begin
                    cal_nxt.min = cal_q.min + 6'd1;
                end else begin
                    cal_nxt.min = 6'd0;
                    if (cal_q.hour < 5'd23) begin
                        cal_nxt.hour = cal_q.hour + 5'd1;
                    end else begin
                        cal_nxt.hour = 5'd0;
                        if (cal_q.day < last_day) begin
                            cal_nxt.day = cal_q.day + 5'd1;
                        end else begin
                            cal_nxt.day = 5'd1;
                            if (cal_q.mon < 4'd12) begin
                                cal_nxt.mon = cal_q.mon + 4'd1;
                            end else begin
                                cal_nxt.mon = 4'd1;
                                year_carry  = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q <= CAL_RESET;
        end else if (ld_fields) begin
            cal_q <= unpack_time(field_word);
        end else if (run && tick) begin
            cal_q <= cal_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= '0;
        end else if (ld_year) begin
            year_q <= year_word;
        end else if (run && tick && year_carry && !ld_fields) begin
            year_q <= year_q + YEAR_W'(1);
        end
    end

endmodule

// File: rtl/toy_alarm_bank.sv
module toy_alarm_bank
    import toy_pkg::*;
#(
    parameter int NUM_ALARMS = 3,
    parameter int YEAR_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [NUM_ALARMS-1:0]    wr_hit,
    input  logic [31:0]              wdata,
    input  cal_t                     cal_now,
    input  logic [YEAR_W-1:0]        year_now,
    output logic [NUM_ALARMS*32-1:0] alarm_flat,
    output logic [NUM_ALARMS-1:0]    pending
);

    localparam int YLOW_W = 6;

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        logic [31:0] word_q;
        logic        hit;

        always_comb begin
            hit = run
               && (word_q[31:26] == year_now[YLOW_W-1:0])
               && (word_q[25:22] == cal_now.mon)
               && (word_q[21:17] == cal_now.day)
               && (word_q[16:12] == cal_now.hour)
               && (word_q[11:6]  == cal_now.min)
               && (word_q[5:0]   == cal_now.sec);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_hit[i] && run) begin
                word_q <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
            end else if (wr_hit[i] && run) begin
                pending[i] <= 1'b0;
            end else if (hit) begin
                pending[i] <= 1'b1;
            end
        end

        assign alarm_flat[i*32 +: 32] = word_q;
    end

endmodule

// File: rtl/toy_calendar.sv
module toy_calendar
    import toy_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int YEAR_W     = 16,
    parameter int NUM_ALARMS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16hz,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int WORD_BYTES = 4;

    unit_state_e state_q, state_d;
    logic        unit_on;
    logic [31:0] ctrl_q;
    logic [31:0] rd_mux;
    logic        ctrl_wr, ctrl_go;

    logic                     hit_time_wr, hit_year_wr, hit_time_rd, hit_year_rd, hit_ctrl;
    logic [NUM_ALARMS-1:0]    hit_alarm;
    logic [NUM_ALARMS-1:0]    alarm_wr_hit;
    logic [NUM_ALARMS*32-1:0] alarm_flat;
    logic [NUM_ALARMS-1:0]    alarm_pend;
    cal_t                     cal_q;
    logic [YEAR_W-1:0]        year_q;

    assign hit_time_wr = (bus_addr == ADDR_W'(OFS_TIME_WR));
    assign hit_year_wr = (bus_addr == ADDR_W'(OFS_YEAR_WR));
    assign hit_time_rd = (bus_addr == ADDR_W'(OFS_TIME_RD));
    assign hit_year_rd = (bus_addr == ADDR_W'(OFS_YEAR_RD));
    assign hit_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_dec
        assign hit_alarm[i] = (bus_addr == ADDR_W'(OFS_ALARM0) + ADDR_W'(i * WORD_BYTES));
    end

    assign alarm_wr_hit = bus_wr ? hit_alarm : '0;
    assign ctrl_wr      = bus_wr && hit_ctrl;
    assign ctrl_go      = bus_wdata[CTRL_CAL_BIT] && bus_wdata[CTRL_OSC_BIT];

    // Run-state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UNIT_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Run-state machine: next state (GO_ON / GO_OFF)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_OFF: if (ctrl_wr && ctrl_go)  state_d = UNIT_ON;
            UNIT_ON:  if (ctrl_wr && !ctrl_go) state_d = UNIT_OFF;
        endcase
    end

    // Run-state machine: outputs
    always_comb begin
        unique case (state_q)
            UNIT_OFF: unit_on = 1'b0;
            UNIT_ON:  unit_on = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata;
        end
    end

    toy_cal_core #(.YEAR_W(YEAR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (unit_on),
        .tick       (tick_16hz),
        .ld_fields  (bus_wr && hit_time_wr && unit_on),
        .ld_year    (bus_wr && hit_year_wr && unit_on),
        .field_word (bus_wdata[29:0]),
        .year_word  (bus_wdata[YEAR_W-1:0]),
        .cal_q      (cal_q),
        .year_q     (year_q)
    );

    toy_alarm_bank #(.NUM_ALARMS(NUM_ALARMS), .YEAR_W(YEAR_W)) u_alarms (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (unit_on),
        .wr_hit     (alarm_wr_hit),
        .wdata      (bus_wdata),
        .cal_now    (cal_q),
        .year_now   (year_q),
        .alarm_flat (alarm_flat),
        .pending    (alarm_pend)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_time_rd && unit_on) rd_mux = pack_time(cal_q);
        if (hit_year_rd && unit_on) rd_mux = 32'(year_q);
        if (hit_ctrl)               rd_mux = ctrl_q;
        for (int i = 0; i < NUM_ALARMS; i++) begin
            if (hit_alarm[i]) rd_mux = alarm_flat[i*32 +: 32];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign irq = |alarm_pend;

endmodule

// File: rtl/toy_calendar_chk.sv
module toy_calendar_chk
    import toy_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_ALARMS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_16hz,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata,
    input logic                  irq,
    input logic                  unit_on,
    input cal_t                  cal_now,
    input logic [NUM_ALARMS-1:0] pending
);

    // R3: a stopped unit keeps its calendar when nothing is written
    assert_frozen_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_on && !bus_wr) |=> $stable(cal_now));

    // R3: time read while stopped returns zero
    assert_zero_read_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !unit_on && bus_addr == ADDR_W'(OFS_TIME_RD)) |=> (bus_rdata == 32'd0));

    // R9: no new interrupt arises from a stopped unit
    assert_no_irq_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_on |=> !$rose(irq));

    // R10: writing alarm 0 while running clears its flag
    assert_alarm_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unit_on && bus_addr == ADDR_W'(OFS_ALARM0)) |=> !pending[0]);

    // R5: a tick on a running unit with no write moves the calendar
    assert_tick_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_on && tick_16hz && !bus_wr) |=> (cal_now != $past(cal_now)));

endmodule

bind toy_calendar toy_calendar_chk #(.ADDR_W(ADDR_W), .NUM_ALARMS(NUM_ALARMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_16hz (tick_16hz),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .unit_on   (unit_on),
    .cal_now   (cal_q),
    .pending   (alarm_pend)
);

// File: tb/tb_toy_calendar.sv
module tb_toy_calendar;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] K_WR  = 2'd0;
    localparam logic [1:0] K_RD  = 2'd1;
    localparam logic [1:0] K_TK  = 2'd2;
    localparam logic [1:0] K_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] tw(input int mo, input int d, input int h,
                                       input int mi, input int s, input int sb);
        tw = {mo[5:0], d[4:0], h[4:0], mi[5:0], s[5:0], sb[3:0]};
    endfunction

    function automatic logic [31:0] aw(input int y, input int mo, input int d,
                                       input int h, input int mi, input int s);
        aw = {y[5:0], mo[3:0], d[4:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    localparam int NV = 80;
    localparam vec_t VECS [NV] = '{
        // R1 reset values
        '{K_RD, 8'h40, 32'h0, 32'h0, 8'd1},
        '{K_RD, 8'h34, 32'h0, 32'h0, 8'd1},
        '{K_RD, 8'h3C, 32'h0, 32'h0, 8'd1},
        // R3 time write while stopped; R2 single-bit control does not start
        '{K_WR, 8'h24, tw(3,4,5,6,7,0), 32'h0, 8'd3},
        '{K_WR, 8'h40, 32'h800, 32'h0, 8'd2},
        '{K_RD, 8'h40, 32'h0, 32'h800, 8'd2},
        '{K_RD, 8'h2C, 32'h0, 32'h0, 8'd2},
        '{K_WR, 8'h40, 32'h100, 32'h0, 8'd2},
        '{K_RD, 8'h2C, 32'h0, 32'h0, 8'd2},
        '{K_WR, 8'h40, 32'h900, 32'h0, 8'd2},
        '{K_RD, 8'h2C, 32'h0, tw(1,1,0,0,0,0), 8'd3},
        // R4 field and year access
        '{K_RD, 8'h30, 32'h0, 32'd0, 8'd4},
        '{K_WR, 8'h24, tw(3,4,5,6,7,0), 32'h0, 8'd4},
        '{K_RD, 8'h2C, 32'h0, tw(3,4,5,6,7,0), 8'd4},
        '{K_WR, 8'h28, 32'd2024, 32'h0, 8'd4},
        '{K_RD, 8'h30, 32'h0, 32'd2024, 8'd4},
        // R5 sixteenths
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd5},
        '{K_RD, 8'h2C, 32'h0, tw(3,4,5,6,7,1), 8'd5},
        '{K_TK, 8'h00, 32'd15, 32'h0, 8'd5},
        '{K_RD, 8'h2C, 32'h0, tw(3,4,5,6,8,0), 8'd5},
        // R7 February in a leap year
        '{K_WR, 8'h24, tw(2,28,23,59,59,15), 32'h0, 8'd7},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd7},
        '{K_RD, 8'h2C, 32'h0, tw(2,29,0,0,0,0), 8'd7},
        '{K_WR, 8'h24, tw(2,29,23,59,59,15), 32'h0, 8'd7},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd7},
        '{K_RD, 8'h2C, 32'h0, tw(3,1,0,0,0,0), 8'd7},
        // R7 February in a common year
        '{K_WR, 8'h28, 32'd2023, 32'h0, 8'd7},
        '{K_WR, 8'h24, tw(2,28,23,59,59,15), 32'h0, 8'd7},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd7},
        '{K_RD, 8'h2C, 32'h0, tw(3,1,0,0,0,0), 8'd7},
        // R6 year rollover
        '{K_WR, 8'h24, tw(12,31,23,59,59,15), 32'h0, 8'd6},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd6},
        '{K_RD, 8'h2C, 32'h0, tw(1,1,0,0,0,0), 8'd6},
        '{K_RD, 8'h30, 32'h0, 32'd2024, 8'd6},
        // R6 hour carry
        '{K_WR, 8'h24, tw(6,15,10,59,59,15), 32'h0, 8'd6},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd6},
        '{K_RD, 8'h2C, 32'h0, tw(6,15,11,0,0,0), 8'd6},
        // R7 thirty-day month
        '{K_WR, 8'h24, tw(4,30,23,59,59,15), 32'h0, 8'd7},
        '{K_TK, 8'h00, 32'd1, 32'h0, 8'd7},
        '{K_RD, 8'h2C, 32'h0, tw(5,1,0,0,0,0), 8'd7},
        // R11 unmapped offsets
        '{K_RD, 8'h20, 32'h0, 32'h0, 8'd11},
        '{K_WR, 8'h44, 32'hFFFF_FFFF, 32'h0, 8'd11},
        '{K_RD, 8'h44, 32'h0, 32'h0, 8'd11},
        '{K_RD, 8'h40, 32'h0, 32'h900, 8'd11},
        // R8 alarm readback
        '{K_WR, 8'h38, aw(40,5,1,0,0,7), 32'h0, 8'd8},
        '{K_RD, 8'h38, 32'h0, aw(40,5,1,0,0,7), 8'd8},
        // R9 match raises interrupt (year 2024, low six bits 40)
        '{K_WR, 8'h34, aw(40,5,1,0,0,1), 32'h0, 8'd9},
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd9},
        '{K_TK, 8'h00, 32'd16, 32'h0, 8'd9},
        '{K_IRQ, 8'h00, 32'h0, 32'd1, 8'd9},
        // R10 sticky, then cleared by write
        '{K_TK, 8'h00, 32'd16, 32'h0, 8'd10},
        '{K_IRQ, 8'h00, 32'h0, 32'd1, 8'd10},
        '{K_WR, 8'h34, aw(40,5,1,0,0,3), 32'h0, 8'd10},
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd10},
        '{K_RD, 8'h34, 32'h0, aw(40,5,1,0,0,3), 8'd8},
        '{K_TK, 8'h00, 32'd16, 32'h0, 8'd10},
        '{K_IRQ, 8'h00, 32'h0, 32'd1, 8'd10},
        '{K_WR, 8'h34, 32'h0, 32'h0, 8'd10},
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd10},
        // R9 year low bits differ: no match
        '{K_WR, 8'h3C, aw(41,5,1,0,0,5), 32'h0, 8'd9},
        '{K_TK, 8'h00, 32'd32, 32'h0, 8'd9},
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd9},
        // R3 stopped unit: frozen, zero reads, dropped writes
        '{K_WR, 8'h40, 32'h100, 32'h0, 8'd3},
        '{K_TK, 8'h00, 32'd48, 32'h0, 8'd3},
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd3},
        '{K_RD, 8'h2C, 32'h0, 32'h0, 8'd3},
        '{K_RD, 8'h30, 32'h0, 32'h0, 8'd3},
        '{K_WR, 8'h38, aw(40,5,1,0,0,9), 32'h0, 8'd3},
        '{K_RD, 8'h38, 32'h0, aw(40,5,1,0,0,7), 8'd8},
        '{K_WR, 8'h24, tw(7,7,7,7,7,7), 32'h0, 8'd3},
        '{K_WR, 8'h28, 32'd99, 32'h0, 8'd3},
        '{K_RD, 8'h40, 32'h0, 32'h100, 8'd2},
        '{K_WR, 8'h40, 32'h900, 32'h0, 8'd2},
        '{K_RD, 8'h2C, 32'h0, tw(5,1,0,0,5,0), 8'd3},
        '{K_RD, 8'h30, 32'h0, 32'd2024, 8'd3},
        // R9 alarm 1 fires after restart
        '{K_IRQ, 8'h00, 32'h0, 32'd0, 8'd9},
        '{K_TK, 8'h00, 32'd32, 32'h0, 8'd9},
        '{K_IRQ, 8'h00, 32'h0, 32'd1, 8'd9},
        '{K_RD, 8'h2C, 32'h0, tw(5,1,0,0,7,0), 8'd9},
        '{K_RD, 8'h3C, 32'h0, aw(41,5,1,0,0,5), 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_16hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toy_calendar dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_16hz (tick_16hz),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_16hz = 1'b1;
            @(negedge clk);
            tick_16hz = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({31'd0, irq}, 32'd0, 1, "irq after reset");

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].kind)
                K_WR:  do_wr(VECS[i].addr, VECS[i].data);
                K_RD: begin
                    do_rd(VECS[i].addr, rd);
                    check(rd, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d read", i));
                end
                K_TK:  do_ticks(int'(VECS[i].data));
                K_IRQ: begin
                    @(negedge clk);
                    check({31'd0, irq}, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d irq", i));
                end
            endcase
        end

        // R1: reset in mid-run clears control, alarms and interrupt
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check({31'd0, irq}, 32'd0, 1, "irq after mid-run reset");
        do_rd(8'h40, rd);
        check(rd, 32'h0, 1, "control after mid-run reset");
        do_rd(8'h38, rd);
        check(rd, 32'h0, 1, "alarm 1 after mid-run reset");
        do_rd(8'h2C, rd);
        check(rd, 32'h0, 3, "time read after reset (stopped)");

        // R4: read data holds after the strobe drops
        do_wr(8'h40, 32'h900);
        do_rd(8'h2C, rd);
        @(negedge clk);
        check(bus_rdata, tw(1,1,0,0,0,0), 4, "read data holds");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule